// File: doc/BRIEF.md
# Round-Robin Sample Splitter with Staggered Channel Start

This block takes one high-rate sample stream and hands the samples out in turn to `NUM_CH` identical downstream processing lanes. Each lane therefore sees every `NUM_CH`-th sample at `1/NUM_CH` of the input rate. The lanes run with identical filter, gain and frequency settings. Only two things differ between lanes: when each one starts, and the phase offset of its oscillator. With both set this way, the lane outputs can be summed back into one coherent wideband signal.

A start strobe (`sync_i`) restarts the distribution at lane 0 and restarts a count of input samples. Lane `k` receives a one-clock start pulse when the sample with index `HOLD_BASE + k` since the strobe is accepted. This staggers the lane start-up by one input sample period per lane, in the same order as the lanes receive their first samples. Each lane also has a constant oscillator phase offset of `k * floor(2^PHASE_W / NUM_CH)`. The filters and oscillators themselves live outside this block.

Top module: `stagger_splitter`

## Requirements
- R1: While `rst_n` is low, every bit of `ch_valid_o`, `ch_start_o` and `ch_data_o` is 0.
- R2: One clock after a cycle with `in_valid_i` high, exactly one bit of `ch_valid_o` is high for one clock. After a cycle with `in_valid_i` low, no bit of `ch_valid_o` is high.
- R3: Accepted samples go to lanes 0, 1, ..., `NUM_CH-1`, 0, ... in that order, one lane per accepted sample. Cycles with `in_valid_i` low do not advance the order. After reset the first sample goes to lane 0.
- R4: A sample accepted in the same cycle as `sync_i` goes to lane 0, and the order continues from there.
- R5: The lane that receives a sample shows it on its slice `ch_data_o[k*DATA_W +: DATA_W]` one clock later. The slices of all other lanes hold their values.
- R6: `ch_phase_o[k*PHASE_W +: PHASE_W]` equals `k * floor(2^PHASE_W / NUM_CH)`, truncated to `PHASE_W` bits. With 4 lanes and 16 bits this gives 0, 16384, 32768 and 49152. With 3 lanes it gives 0, 21845 and 43690.
- R7: Samples are counted from 0, starting with the sample accepted together with `sync_i` or the first one accepted after it. `ch_start_o[k]` pulses high for one clock, one clock after the sample with index `HOLD_BASE + k` is accepted. It pulses exactly once per strobe.
- R8: Between reset and the first `sync_i`, `ch_start_o` stays 0 whatever samples arrive.
- R9: A cycle with `in_valid_i` low and `sync_i` low changes no lane data and raises no valid or start bit.
- R10: A `sync_i` pulse with `in_valid_i` low still restarts the order and the count. The next accepted sample goes to lane 0 as sample index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Start strobe: restarts lane order and sample count |
| in_valid_i | input | 1 | Input sample valid |
| in_data_i | input | DATA_W | Input sample |
| ch_valid_o | output | NUM_CH | Per-lane one-clock sample pulse |
| ch_data_o | output | NUM_CH*DATA_W | Per-lane held sample, lane k at bits k*DATA_W |
| ch_start_o | output | NUM_CH | Per-lane one-clock start pulse |
| ch_phase_o | output | NUM_CH*PHASE_W | Per-lane oscillator phase offset |

## Verification
Lane valid, lane data and lane start are all registered exactly once. Each is due in the first clock after the edge that accepts the input, and phase offsets are static. The bench drives inputs at the falling edge, advances one rising edge, and compares all outputs 1 ns later against a cycle model of lane index and sample count, run arithmetically in the bench. A long sweep mixes idle gaps, strobes with and without samples, and samples before any strobe, so each output is checked in the single cycle it is due.

// File: rtl/stagger_pkg.sv
package stagger_pkg;

   // Phase offset of lane k for n lanes over a 2^pw range, truncated to pw bits.
   function automatic logic [31:0] lane_phase(input int k, input int n, input int pw);
      longint span;
      longint step;
      span = longint'(1) << pw;
      step = span / n;
      return 32'((step * k) % span);
   endfunction

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/stagger_seq.sv
module stagger_seq #(
   parameter int NUM_CH = 4,
   parameter int LIMIT  = 4,
   parameter int IDX_W  = 2,
   parameter int CNT_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_i,
   input  logic             take_i,
   output logic [IDX_W-1:0] idx_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             live_o
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CH - 1);
   localparam logic [CNT_W-1:0] CNT_END  = CNT_W'(LIMIT);

   logic [IDX_W-1:0] idx_q;
   logic [CNT_W-1:0] cnt_q;

   // Strobe overrides the stored state in the same cycle.
   assign idx_o  = sync_i ? '0 : idx_q;
   assign cnt_o  = sync_i ? '0 : cnt_q;
   assign live_o = (cnt_o < CNT_END);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
         cnt_q <= CNT_END;
      end else begin
         if (take_i)
            idx_q <= (idx_o == LAST_IDX) ? '0 : idx_o + 1'b1;
         else
            idx_q <= idx_o;
         if (take_i && live_o)
            cnt_q <= cnt_o + 1'b1;
         else
            cnt_q <= cnt_o;
      end
   end
endmodule

// File: rtl/stagger_lane.sv
module stagger_lane #(
   parameter int DATA_W   = 16,
   parameter int CNT_W    = 3,
   parameter int START_AT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take_i,
   input  logic              hit_i,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic              live_i,
   input  logic [DATA_W-1:0] din_i,
   output logic              valid_o,
   output logic [DATA_W-1:0] data_o,
   output logic              start_o
);
   localparam logic [CNT_W-1:0] START_CNT = CNT_W'(START_AT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         data_o  <= '0;
         start_o <= 1'b0;
      end else begin
         valid_o <= take_i && hit_i;
         if (take_i && hit_i)
            data_o <= din_i;
         start_o <= take_i && live_i && (cnt_i == START_CNT);
      end
   end
endmodule

// File: rtl/stagger_splitter.sv
module stagger_splitter
   import stagger_pkg::*;
#(
   parameter int NUM_CH    = 4,
   parameter int DATA_W    = 16,
   parameter int PHASE_W   = 16,
   parameter int HOLD_BASE = 0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        sync_i,
   input  logic                        in_valid_i,
   input  logic [DATA_W-1:0]           in_data_i,
   output logic [NUM_CH-1:0]           ch_valid_o,
   output logic [NUM_CH*DATA_W-1:0]    ch_data_o,
   output logic [NUM_CH-1:0]           ch_start_o,
   output logic [NUM_CH*PHASE_W-1:0]   ch_phase_o
);
   localparam int LIMIT = HOLD_BASE + NUM_CH;
   localparam int IDX_W = idx_width(NUM_CH);
   localparam int CNT_W = $clog2(LIMIT + 1);

   if (NUM_CH < 1 || NUM_CH > 4) begin : g_bad_ch
      $error("stagger_splitter: NUM_CH must be 1..4");
   end
   if (PHASE_W < 2 || PHASE_W > 31) begin : g_bad_phase
      $error("stagger_splitter: PHASE_W must be 2..31");
   end
   if (HOLD_BASE < 0) begin : g_bad_hold
      $error("stagger_splitter: HOLD_BASE must not be negative");
   end

   logic [IDX_W-1:0] sel_idx;
   logic [CNT_W-1:0] smp_cnt;
   logic             cnt_live;

   stagger_seq #(
      .NUM_CH(NUM_CH), .LIMIT(LIMIT), .IDX_W(IDX_W), .CNT_W(CNT_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .take_i(in_valid_i),
      .idx_o(sel_idx), .cnt_o(smp_cnt), .live_o(cnt_live)
   );

   for (genvar k = 0; k < NUM_CH; k++) begin : g_lane
      localparam logic [31:0] PH = lane_phase(k, NUM_CH, PHASE_W);
      logic hit;

      if (NUM_CH == 1) begin : g_single
         assign hit = 1'b1;
      end else begin : g_multi
         assign hit = (sel_idx == IDX_W'(k));
      end

      stagger_lane #(
         .DATA_W(DATA_W), .CNT_W(CNT_W), .START_AT(HOLD_BASE + k)
      ) u_lane (
         .clk(clk), .rst_n(rst_n), .take_i(in_valid_i), .hit_i(hit),
         .cnt_i(smp_cnt), .live_i(cnt_live), .din_i(in_data_i),
         .valid_o(ch_valid_o[k]),
         .data_o(ch_data_o[k*DATA_W +: DATA_W]),
         .start_o(ch_start_o[k])
      );

      assign ch_phase_o[k*PHASE_W +: PHASE_W] = PH[PHASE_W-1:0];
   end
endmodule

// File: rtl/stagger_splitter_chk.sv
module stagger_splitter_chk #(
   parameter int NUM_CH = 4,
   parameter int DATA_W = 16
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     sync_i,
   input logic                     in_valid_i,
   input logic [DATA_W-1:0]        in_data_i,
   input logic [NUM_CH-1:0]        ch_valid_o,
   input logic [NUM_CH*DATA_W-1:0] ch_data_o,
   input logic [NUM_CH-1:0]        ch_start_o
);
   // R1: outputs cleared while reset is held
   a_r1_reset_clear: assert property (@(posedge clk)
      !rst_n |-> (ch_valid_o == '0 && ch_start_o == '0));

   // R2: each accepted sample lands on exactly one lane
   a_r2_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid_i |=> $onehot(ch_valid_o));

   // R9: idle input raises no lane valid
   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid_i |=> (ch_valid_o == '0 && ch_start_o == '0));

   // R4: strobe-aligned sample goes to lane 0
   a_r4_sync_lane0: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_i && in_valid_i) |=> ch_valid_o[0]);

   // R5: lane 0 carries the strobe-aligned sample
   a_r5_sync_data: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_i && in_valid_i) |=> (ch_data_o[DATA_W-1:0] == $past(in_data_i)));

   // R7: at most one lane starts per cycle
   a_r7_start_single: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ch_start_o));
endmodule

bind stagger_splitter stagger_splitter_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .in_valid_i(in_valid_i),
   .in_data_i(in_data_i), .ch_valid_o(ch_valid_o), .ch_data_o(ch_data_o),
   .ch_start_o(ch_start_o)
);

// File: tb/stagger_splitter_test.sv
`timescale 1ns/1ps
module stagger_splitter_test;
   localparam int N    = 4;
   localparam int DW   = 16;
   localparam int PW   = 16;
   localparam int HB   = 3;
   localparam int LIM  = HB + N;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sync_i = 1'b0;
   logic in_valid_i = 1'b0;
   logic [DW-1:0] in_data_i = '0;
   logic [N-1:0] ch_valid_o, ch_start_o;
   logic [N*DW-1:0] ch_data_o;
   logic [N*PW-1:0] ch_phase_o;
   logic [2:0] v3, s3;
   logic [3*DW-1:0] d3;
   logic [3*PW-1:0] p3;

   int checks = 0;
   int errors = 0;
   int m_idx = 0;
   int m_cnt = LIM;
   logic [DW-1:0] m_data [N];

   always #2.5 clk = ~clk;

   stagger_splitter #(.NUM_CH(N), .DATA_W(DW), .PHASE_W(PW), .HOLD_BASE(HB)) uut (
      .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .in_valid_i(in_valid_i),
      .in_data_i(in_data_i), .ch_valid_o(ch_valid_o), .ch_data_o(ch_data_o),
      .ch_start_o(ch_start_o), .ch_phase_o(ch_phase_o));

   stagger_splitter #(.NUM_CH(3), .DATA_W(DW), .PHASE_W(PW), .HOLD_BASE(0)) uut_n3 (
      .clk(clk), .rst_n(rst_n), .sync_i(1'b0), .in_valid_i(1'b0),
      .in_data_i('0), .ch_valid_o(v3), .ch_data_o(d3),
      .ch_start_o(s3), .ch_phase_o(p3));

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic step(input logic s, input logic v, input logic [DW-1:0] d, input string vtag);
      int e_idx, e_cnt;
      logic [N-1:0] e_valid, e_start;
      bit armed;
      @(negedge clk);
      sync_i = s; in_valid_i = v; in_data_i = d;
      e_idx = s ? 0 : m_idx;
      e_cnt = s ? 0 : m_cnt;
      armed = (e_cnt < LIM);
      e_valid = '0; e_start = '0;
      if (v) begin
         e_valid[e_idx] = 1'b1;
         m_data[e_idx] = d;
         if (armed) e_start[e_cnt - HB] = (e_cnt >= HB);
      end
      @(posedge clk); #1;
      chk(vtag, longint'(ch_valid_o), longint'(e_valid));
      chk("R2", $countones(ch_valid_o), v ? 1 : 0);
      chk(m_cnt >= LIM && !s ? "R8/R7" : "R7", longint'(ch_start_o), longint'(e_start));
      for (int k = 0; k < N; k++)
         chk(v ? "R5" : "R9", longint'(ch_data_o[k*DW +: DW]), longint'(m_data[k]));
      m_idx = v ? (e_idx + 1) % N : e_idx;
      m_cnt = (v && armed) ? e_cnt + 1 : e_cnt;
   endtask

   initial begin : watchdog
      #500000;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int k = 0; k < N; k++) m_data[k] = '0;
      repeat (3) @(posedge clk);
      #1;
      chk("R1", longint'(ch_valid_o), 0);
      chk("R1", longint'(ch_start_o), 0);
      chk("R1", longint'(ch_data_o), 0);
      // R6 phase offsets for 4 and 3 lanes
      for (int k = 0; k < N; k++) chk("R6", longint'(ch_phase_o[k*PW +: PW]), k * 16384);
      for (int k = 0; k < 3; k++) chk("R6", longint'(p3[k*PW +: PW]), k * 21845);
      @(negedge clk); rst_n = 1'b1;

      // R8: samples before any strobe; R3 order from lane 0
      for (int i = 0; i < 6; i++) step(1'b0, 1'b1, DW'(16'h100 + i), "R3");
      // R4: strobe with sample mid-order
      step(1'b1, 1'b1, 16'hA5A5, "R4");
      for (int i = 0; i < 9; i++) step(1'b0, (i % 3) != 1, DW'(16'h200 + i), "R3");
      // R10: strobe alone, then next sample to lane 0
      step(1'b0, 1'b1, 16'h0BAD, "R3");
      step(1'b1, 1'b0, 16'hFFFF, "R10");
      step(1'b0, 1'b1, 16'h1234, "R10");
      for (int i = 0; i < 8; i++) step(1'b0, 1'b1, DW'(16'h300 + i), "R7");
      // Sweep: mixed gaps and strobes
      for (int i = 0; i < 400; i++)
         step((i % 37) == 20, (i % 5) != 2, DW'(i * 13 + 7), "R3");
      @(negedge clk);
      sync_i = 1'b0; in_valid_i = 1'b0;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule